// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block captures one incoming vector-interrupt event at a time. An upstream source presents a one-cycle event strobe with a level bit (1 = raise, 0 = lower) and a 6-bit interrupt number. When a raise arrives while nothing is held, the latch sets its busy flag. It packs a fixed source field over the interrupt number into the first of three 64-bit data words and clears the other two. It then raises a hard interrupt request carrying the vector trap type, and pulses a wake signal so that a halted core resumes.

While the busy flag is set, further raises are ignored and the held payload stays as it is. A separate output tells the level-interrupt priority resolver to hold off its evaluation. A lower event clears busy and withdraws the request. The payload words keep their last values until the next accepted raise.

Top module: `ivec_latch`

## Requirements
- R1: After reset, busy, levelBlock, hardReq and wake are 0, trapType is 0, and all three data words are 0.
- R2: A raise event (evtValid=1, evtLevel=1) while busy is 0 sets busy and hardReq, and sets trapType to 0x60, at the next clock edge.
- R3: An accepted raise loads dataWord0 with bits [5:0] = evtNum, bits [10:6] = 5'h1F and all higher bits 0. It loads dataWord1 and dataWord2 with 0.
- R4: A raise event while busy is 1 is ignored. Busy, hardReq, trapType and all data words keep their values, and wake stays 0.
- R5: A lower event (evtValid=1, evtLevel=0) while busy is 1 clears busy and hardReq and returns trapType to 0 at the next edge. The data words keep their values.
- R6: A lower event while busy is 0 changes no output.
- R7: wake is high for exactly the one cycle that follows each accepted raise, and is 0 otherwise.
- R8: levelBlock is 1 exactly while busy is 1.
- R9: With evtValid at 0, no output changes, whatever evtLevel and evtNum carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | One-cycle event strobe |
| evtLevel | input | 1 | 1 = raise, 0 = lower |
| evtNum | input | 6 | Interrupt number |
| busy | output | 1 | Vector held |
| levelBlock | output | 1 | Hold off level-interrupt evaluation |
| dataWord0 | output | 64 | Packed source/number word |
| dataWord1 | output | 64 | Payload word 1 |
| dataWord2 | output | 64 | Payload word 2 |
| hardReq | output | 1 | Hard interrupt request |
| trapType | output | 9 | Trap type, 0x60 while held |
| wake | output | 1 | One-cycle wake-from-halt pulse |

## Verification
The hardest case to reach is a second raise that arrives while a vector is already held. Its own, different interrupt number must not leak into the held payload. The bench first brings the latch to busy with one number. It then sends raises carrying other numbers, and also a raise in the same cycle position right after a lower, and compares every data word against the first capture. Lower events sent while idle, and level or number inputs toggled with the strobe low, then show that the only path to a state change is a valid strobe.

// File: rtl/ivec_latch_pkg.sv
package ivec_latch_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } ivecStrobes_t;
endpackage

// File: rtl/ivec_latch_ctrl.sv
module ivec_latch_ctrl
  import ivec_latch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtValid,
  input  logic         evtLevel,
  output logic         busyQ,
  output ivecStrobes_t strobes
);
  logic raiseEvt;
  logic lowerEvt;

  assign raiseEvt = evtValid && evtLevel;
  assign lowerEvt = evtValid && !evtLevel;

  always_comb begin
    strobes.load  = raiseEvt && !busyQ;
    strobes.clear = lowerEvt && busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobes.load) begin
      busyQ <= 1'b1;
    end else if (strobes.clear) begin
      busyQ <= 1'b0;
    end
  end

  assert_raise_sets_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtLevel && !busyQ) |=> busyQ);
  assert_busy_ignores_raise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtLevel && busyQ) |=> busyQ);
  assert_lower_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtLevel && busyQ) |=> !busyQ);
  assert_idle_lower_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtLevel && !busyQ) |=> !busyQ);
  assert_no_event_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |=> $stable(busyQ));
endmodule

// File: rtl/ivec_latch_datapath.sv
module ivec_latch_datapath
  import ivec_latch_pkg::*;
#(
  parameter int NUM_W    = 6,
  parameter int DATA_W   = 64,
  parameter int WORDS    = 3,
  parameter int SRC_W    = 5,
  parameter int SRC_VAL  = 'h1F,
  parameter int TRAP_W   = 9,
  parameter int TRAP_VEC = 'h60
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_W-1:0]      evtNum,
  input  ivecStrobes_t          strobes,
  input  logic                  busyQ,
  output logic [DATA_W-1:0]     dataWords [WORDS],
  output logic                  hardReq,
  output logic [TRAP_W-1:0]     trapType,
  output logic                  wake
);
  localparam int SRC_LSB = NUM_W;
  localparam logic [SRC_W-1:0]  SRC_FIELD = SRC_W'(SRC_VAL);
  localparam logic [TRAP_W-1:0] TRAP_CODE = TRAP_W'(TRAP_VEC);

  logic [DATA_W-1:0] packedWord;

  always_comb begin
    packedWord = '0;
    packedWord[NUM_W-1:0] = evtNum;
    packedWord[SRC_LSB +: SRC_W] = SRC_FIELD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataWords[0] <= '0;
    end else if (strobes.load) begin
      dataWords[0] <= packedWord;
    end
  end

  for (genvar w = 1; w < WORDS; w++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN || strobes.load) begin
        dataWords[w] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hardReq  <= 1'b0;
      trapType <= '0;
      wake     <= 1'b0;
    end else begin
      wake <= strobes.load;
      if (strobes.load) begin
        hardReq  <= 1'b1;
        trapType <= TRAP_CODE;
      end else if (strobes.clear) begin
        hardReq  <= 1'b0;
        trapType <= '0;
      end
    end
  end

  assert_req_tracks_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    hardReq == busyQ);
  assert_word0_pack_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (dataWords[0][NUM_W-1:0] == $past(evtNum)
                      && dataWords[0][SRC_LSB +: SRC_W] == SRC_FIELD));
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(dataWords[0]));
  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    wake |=> !wake);
endmodule

// File: rtl/ivec_latch.sv
module ivec_latch
  import ivec_latch_pkg::*;
#(
  parameter int NUM_W    = 6,
  parameter int DATA_W   = 64,
  parameter int TRAP_W   = 9,
  parameter int TRAP_VEC = 'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic              evtLevel,
  input  logic [NUM_W-1:0]  evtNum,
  output logic              busy,
  output logic              levelBlock,
  output logic [DATA_W-1:0] dataWord0,
  output logic [DATA_W-1:0] dataWord1,
  output logic [DATA_W-1:0] dataWord2,
  output logic              hardReq,
  output logic [TRAP_W-1:0] trapType,
  output logic              wake
);
  localparam int WORDS = 3;

  ivecStrobes_t      strobes;
  logic              busyQ;
  logic [DATA_W-1:0] words [WORDS];

  ivec_latch_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .evtLevel (evtLevel),
    .busyQ    (busyQ),
    .strobes  (strobes)
  );

  ivec_latch_datapath #(
    .NUM_W    (NUM_W),
    .DATA_W   (DATA_W),
    .WORDS    (WORDS),
    .TRAP_W   (TRAP_W),
    .TRAP_VEC (TRAP_VEC)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtNum    (evtNum),
    .strobes   (strobes),
    .busyQ     (busyQ),
    .dataWords (words),
    .hardReq   (hardReq),
    .trapType  (trapType),
    .wake      (wake)
  );

  assign busy       = busyQ;
  assign levelBlock = busyQ;
  assign dataWord0  = words[0];
  assign dataWord1  = words[1];
  assign dataWord2  = words[2];

  assert_block_matches_R8: assert property (@(posedge clk) disable iff (!rstN)
    levelBlock == hardReq);
endmodule

// File: tb/test_ivec_latch.sv
module test_ivec_latch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic        evtLevel = 1'b0;
  logic [5:0]  evtNum = '0;
  logic        busy, levelBlock, hardReq, wake;
  logic [63:0] dataWord0, dataWord1, dataWord2;
  logic [8:0]  trapType;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ivec_latch i_ivec_latch (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtLevel(evtLevel),
    .evtNum(evtNum), .busy(busy), .levelBlock(levelBlock),
    .dataWord0(dataWord0), .dataWord1(dataWord1), .dataWord2(dataWord2),
    .hardReq(hardReq), .trapType(trapType), .wake(wake)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packed0(input logic [5:0] n);
    return {53'd0, 5'h1F, n};
  endfunction

  // apply one event for one cycle; leave at the negedge after the capturing edge
  task automatic sendEvt(input logic lvl, input logic [5:0] n);
    @(negedge clk);
    evtValid = 1'b1; evtLevel = lvl; evtNum = n;
    @(negedge clk);
    evtValid = 1'b0; evtLevel = 1'b0; evtNum = 6'h2A;
  endtask

  task automatic checkHeld(input string req, input logic b, input logic [63:0] w0);
    chk(req, busy, b);
    chk("R8", levelBlock, b);
    chk(req, hardReq, b);
    chk(req, trapType, b ? 9'h060 : 9'h000);
    chk(req, dataWord0, w0);
    chk(req, dataWord1, 64'd0);
    chk(req, dataWord2, 64'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    checkHeld("R1", 1'b0, 64'd0);
    chk("R1", wake, 1'b0);
  endtask

  task automatic testIdleLower();
    sendEvt(1'b0, 6'h05);
    checkHeld("R6", 1'b0, 64'd0);
    chk("R6", wake, 1'b0);
  endtask

  task automatic testRaise(input logic [5:0] n);
    sendEvt(1'b1, n);
    checkHeld("R2", 1'b1, packed0(n));
    chk("R3", dataWord0, packed0(n));
    chk("R7", wake, 1'b1);
    @(negedge clk);
    chk("R7", wake, 1'b0);
  endtask

  task automatic testRaiseBusy(input logic [5:0] held);
    sendEvt(1'b1, 6'h3F);
    checkHeld("R4", 1'b1, packed0(held));
    chk("R4", wake, 1'b0);
    sendEvt(1'b1, 6'h00);
    checkHeld("R4", 1'b1, packed0(held));
  endtask

  task automatic testNoValid(input logic b, input logic [63:0] w0);
    @(negedge clk);
    evtLevel = ~b; evtNum = 6'h11;
    @(negedge clk);
    evtLevel = b; evtNum = 6'h22;
    @(negedge clk);
    checkHeld("R9", b, w0);
    chk("R9", wake, 1'b0);
  endtask

  task automatic testLower(input logic [5:0] held);
    sendEvt(1'b0, 6'h01);
    checkHeld("R5", 1'b0, packed0(held));
    chk("R5", wake, 1'b0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testIdleLower();
    testNoValid(1'b0, 64'd0);
    testRaise(6'h15);
    testRaiseBusy(6'h15);
    testNoValid(1'b1, packed0(6'h15));
    testLower(6'h15);
    testIdleLower2: begin
      sendEvt(1'b0, 6'h07);
      checkHeld("R6", 1'b0, packed0(6'h15));
    end
    testRaise(6'h3F);
    testLower(6'h3F);
    testRaise(6'h00);
    testRaiseBusy(6'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule